// File: doc/BRIEF.md
# Programmable Tap-Select Ripple Timer

This block is a synchronous model of a 24-stage binary divider chain. The chain advances on each falling edge of a slow, asynchronous tick input, and a 4-bit select picks one stage to drive a single decode output. The result is a programmable square-wave divider or a long-interval timer. The design runs on a fast system clock. The tick input passes through a synchroniser and a falling-edge detector, so each falling edge becomes a one-cycle advance event.

A preset input clears the chain and forces the output high. After preset releases, the first falling tick edge pulls the output low and the second one starts counting. A clear input forces the output low and empties the chain. A bypass input skips the first eight stages, which makes a 16-stage divider. Two hold inputs freeze the count while the tick source keeps running. Preset, clear and bypass all high together select a test mode, in which the chain splits into three 8-stage sections that count in parallel.

Top module: `tap_timer`

## Requirements
- R1: A falling edge on `tick_in` that is set up before system clock edge k updates the chain at edge k+2. A rising edge never advances the chain.
- R2: While `preset_i` is high and `clear_i` is low, `decode_o` is high in the same cycle and the chain is held at zero.
- R3: After `preset_i` falls, `decode_o` stays high until the first falling tick edge. That edge drives it low without advancing the chain, and the second falling edge makes the first advance.
- R4: While `clear_i` is high outside test mode, `decode_o` is low in the same cycle and the chain is held at zero. Clear overrides preset.
- R5: With `bypass_i` low, the chain is a 24-bit up-counter and select code n (0 to 15) routes count bit n+8 (stage n+9) to `decode_o`.
- R6: With `bypass_i` high, only count bits 8 to 23 advance, as a 16-bit counter with one increment per falling edge, and code n routes bit n+8 (stage n+1 of that chain). Bits 0 to 7 hold.
- R7: While `inhibit_i` or `osc_stop_i` is high, falling tick edges leave the count unchanged. The first falling edge after both go low advances it again.
- R8: With `bypass_i`, `preset_i` and `clear_i` all high, nothing is cleared. Each of the three 8-bit sections increments on every falling edge, and code n reads bit n mod 8 of section 1 or section 2.
- R9: In free run, `decode_o` for code n is a 50% duty square wave. In a window of 2^(n+9) falling edges from zero, it is high for exactly half of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_in | input | 1 | Asynchronous tick source; the chain advances on its falling edges |
| preset_i | input | 1 | Forces the output high and empties the chain |
| clear_i | input | 1 | Forces the output low and empties the chain |
| bypass_i | input | 1 | Skips the first eight stages |
| inhibit_i | input | 1 | Holds the count |
| osc_stop_i | input | 1 | Holds the count, same effect as `inhibit_i` |
| sel_i | input | 4 | Stage select code |
| decode_o | output | 1 | Selected stage, or the forced level |

## Verification
Preset, clear and select act on `decode_o` combinationally, so the bench drives them on a falling system clock edge and samples one nanosecond later. A falling tick edge reaches the chain two system edges after the first edge that sees it. The latency test samples one and two falling clock edges after the drive and expects the old value, then samples on the third and expects the new one. All other tick stimulus waits four system cycles after each falling tick edge before it compares every select code against an arithmetic model of the count.

// File: rtl/tap_timer_pkg.sv
`timescale 1ns/1ps
package tap_timer_pkg;
  localparam int SEC_W_DEF   = 8;
  localparam int NUM_SEC_DEF = 3;
  localparam int SEL_W_DEF   = 4;

  typedef enum logic [1:0] {
    MODE_FULL   = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_TEST   = 2'd2
  } chain_mode_e;

  // count bit driven to the output for a select code
  function automatic int tap_index(input int sec_w, input int sel);
    return sec_w + sel;
  endfunction

  // test mode is all three controls high at once
  function automatic logic is_test(input logic bypass, input logic preset, input logic clear);
    return bypass & preset & clear;
  endfunction
endpackage

// File: rtl/tick_sync.sv
`timescale 1ns/1ps
module tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_fall
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], tick_in};
  end

  assign tick_fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fall,
  input  logic        preset_i,
  input  logic        clear_i,
  input  logic        bypass_i,
  input  logic        hold_i,
  output chain_mode_e mode,
  output logic        chain_clear,
  output logic        advance,
  output logic        force_hi,
  output logic        force_lo,
  output logic        armed
);
  logic test_w;
  logic live_fall;

  assign test_w      = is_test(bypass_i, preset_i, clear_i);
  assign live_fall   = tick_fall & ~hold_i;
  assign mode        = test_w ? MODE_TEST : (bypass_i ? MODE_BYPASS : MODE_FULL);
  assign chain_clear = ~test_w & (preset_i | clear_i);
  assign force_lo    = ~test_w & clear_i;
  assign force_hi    = ~test_w & ~clear_i & preset_i;
  assign advance     = live_fall & ~chain_clear & ~armed;

  // armed: output latch high, waiting for the falling edge that drops it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 1'b0;
    else if (test_w)      armed <= 1'b0;
    else if (clear_i)     armed <= 1'b0;
    else if (preset_i)    armed <= 1'b1;
    else if (live_fall)   armed <= 1'b0;
  end

  // R3
  armed_after_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_i && !clear_i) |=> armed);

  // R3
  armed_blocks_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && live_fall && !preset_i && !clear_i) |=> !armed);
endmodule

// File: rtl/tap_chain.sv
`timescale 1ns/1ps
module tap_chain
  import tap_timer_pkg::*;
#(
  parameter int SEC_W   = SEC_W_DEF,
  parameter int NUM_SEC = NUM_SEC_DEF,
  localparam int CNT_W  = SEC_W * NUM_SEC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  chain_mode_e      mode,
  output logic [CNT_W-1:0] cnt
);
  logic [NUM_SEC-1:0] inc;
  logic [SEC_W-1:0]   sec_q [NUM_SEC];

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic ripple_w;
    logic skip_w;
    if (s == 0) begin : g_first
      assign ripple_w = 1'b1;
      assign skip_w   = 1'b1;
    end else if (s == 1) begin : g_second
      assign ripple_w = &cnt[SEC_W-1:0];
      assign skip_w   = 1'b1;
    end else begin : g_upper
      assign ripple_w = &cnt[s*SEC_W-1:0];
      assign skip_w   = &cnt[s*SEC_W-1:SEC_W];
    end

    always_comb begin
      unique case (mode)
        MODE_TEST:   inc[s] = adv;
        MODE_BYPASS: inc[s] = (s != 0) && adv && skip_w;
        default:     inc[s] = adv & ripple_w;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sec_q[s] <= '0;
      else if (clear)  sec_q[s] <= '0;
      else if (inc[s]) sec_q[s] <= sec_q[s] + SEC_W'(1);
    end

    assign cnt[s*SEC_W +: SEC_W] = sec_q[s];

    // R8
    test_section_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_TEST && adv && !clear) |=> sec_q[s] == ($past(sec_q[s]) + SEC_W'(1)));
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clear) |=> $stable(cnt));

  // R4
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);

  // R6
  bypass_low_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYPASS && !clear) |=> $stable(cnt[SEC_W-1:0]));
endmodule

// File: rtl/tap_timer.sv
`timescale 1ns/1ps
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int SEC_W       = SEC_W_DEF,
  parameter int NUM_SEC     = NUM_SEC_DEF,
  parameter int SEL_W       = SEL_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             preset_i,
  input  logic             clear_i,
  input  logic             bypass_i,
  input  logic             inhibit_i,
  input  logic             osc_stop_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             decode_o
);
  localparam int CNT_W = SEC_W * NUM_SEC;
  localparam int IDX_W = $clog2(CNT_W);

  logic             tick_fall;
  chain_mode_e      mode;
  logic             chain_clear;
  logic             advance;
  logic             force_hi;
  logic             force_lo;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] tap_idx;
  logic             tap_bit;

  tick_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .tick_fall (tick_fall)
  );

  tap_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_fall   (tick_fall),
    .preset_i    (preset_i),
    .clear_i     (clear_i),
    .bypass_i    (bypass_i),
    .hold_i      (inhibit_i | osc_stop_i),
    .mode        (mode),
    .chain_clear (chain_clear),
    .advance     (advance),
    .force_hi    (force_hi),
    .force_lo    (force_lo),
    .armed       (armed)
  );

  tap_chain #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC)) i_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (chain_clear),
    .adv   (advance),
    .mode  (mode),
    .cnt   (cnt)
  );

  assign tap_idx  = IDX_W'(tap_index(SEC_W, int'(sel_i)));
  assign tap_bit  = cnt[tap_idx];
  assign decode_o = force_lo ? 1'b0 : ((force_hi | armed) ? 1'b1 : tap_bit);

  // R3
  armed_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clear_i) |-> decode_o);

  // R4
  clear_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !(bypass_i && preset_i)) |-> !decode_o);
endmodule

// File: tb/test_tap_timer.sv
`timescale 1ns/1ps
module test_tap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       preset_i = 1'b0;
  logic       clear_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic       inhibit_i = 1'b0;
  logic       osc_stop_i = 1'b0;
  logic [3:0] sel_i = 4'd0;
  logic       decode_o;

  int vectors = 0;
  int miscompares = 0;
  logic [23:0] mdl = '0;
  int highs = 0;

  always #2.5 clk = ~clk;

  tap_timer i_tap_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .preset_i(preset_i),
    .clear_i(clear_i), .bypass_i(bypass_i), .inhibit_i(inhibit_i),
    .osc_stop_i(osc_stop_i), .sel_i(sel_i), .decode_o(decode_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: decode_o=%0b expected %0b (sel=%0d model=%06h) at %0t",
               req, got, exp, sel_i, mdl, $time);
    end
  endtask

  // full tick period; the chain settles well before the return
  task automatic tick();
    @(negedge clk) tick_in = 1'b1;
    repeat (3) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic step_model(input int mode);  // 0 full, 1 bypass, 2 test
    if (mode == 0)      mdl = mdl + 24'd1;
    else if (mode == 1) mdl = {mdl[23:8] + 16'd1, mdl[7:0]};
    else                mdl = {mdl[23:16] + 8'd1, mdl[15:8] + 8'd1, mdl[7:0] + 8'd1};
  endtask

  task automatic check_all(input string req);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk) sel_i = 4'(n);
      #1 check(decode_o, mdl[8+n], req);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk) clear_i = 1'b1;
    @(negedge clk) #1 check(decode_o, 1'b0, "R4 clear forces low");
    @(negedge clk) clear_i = 1'b0;
    mdl = '0;
  endtask

  initial begin
    #750000;
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) #1 check(decode_o, 1'b0, "R4 reset state");

    // R1: latency of a falling tick edge, bypass mode, sel 0 -> bit 8
    bypass_i = 1'b1;
    sel_i = 4'd0;
    @(negedge clk) tick_in = 1'b1;
    repeat (4) @(negedge clk);
    #1 check(decode_o, 1'b0, "R1 rising edge does not advance");
    @(negedge clk) tick_in = 1'b0;
    @(negedge clk) #1 check(decode_o, 1'b0, "R1 one cycle after fall");
    @(negedge clk) #1 check(decode_o, 1'b0, "R1 two cycles after fall");
    @(negedge clk) #1 check(decode_o, 1'b1, "R1 three cycles after fall");
    mdl = 24'h000100;
    repeat (3) @(negedge clk);

    // R6: bypass sweep of all codes
    pulse_clear();
    check_all("R6 bypass after clear");
    for (int k = 1; k <= 1100; k++) begin
      tick();
      step_model(1);
      check_all("R6 bypass divider");
    end

    // R2 / R3: preset then two falling edges
    pulse_clear();
    tick(); tick(); tick();
    step_model(1); step_model(1); step_model(1);
    sel_i = 4'd0;
    @(negedge clk) preset_i = 1'b1;
    #1 check(decode_o, 1'b1, "R2 preset forces high");
    @(negedge clk) preset_i = 1'b0;
    mdl = '0;
    repeat (3) @(negedge clk);
    #1 check(decode_o, 1'b1, "R3 latch holds after preset release");
    tick();
    check_all("R3 first fall drops output, no advance");
    tick();
    step_model(1);
    check_all("R3 second fall advances");

    // R4: clear overrides preset outside test mode
    bypass_i = 1'b0;
    @(negedge clk) begin preset_i = 1'b1; clear_i = 1'b1; end
    #1 check(decode_o, 1'b0, "R4 clear beats preset");
    @(negedge clk) begin preset_i = 1'b0; clear_i = 1'b0; end
    mdl = '0;
    repeat (2) @(negedge clk);
    check_all("R4 chain empty after clear+preset");

    // R7: hold inputs in bypass mode
    bypass_i = 1'b1;
    for (int k = 0; k < 5; k++) begin tick(); step_model(1); end
    inhibit_i = 1'b1;
    for (int k = 0; k < 4; k++) tick();
    check_all("R7 inhibit holds count");
    inhibit_i = 1'b0;
    osc_stop_i = 1'b1;
    for (int k = 0; k < 3; k++) tick();
    check_all("R7 osc stop holds count");
    osc_stop_i = 1'b0;
    tick();
    step_model(1);
    check_all("R7 resumes on next fall");

    // R5 / R9: full 24-bit chain
    bypass_i = 1'b0;
    pulse_clear();
    highs = 0;
    for (int k = 1; k <= 520; k++) begin
      tick();
      step_model(0);
      @(negedge clk) sel_i = 4'd0;
      #1 check(decode_o, mdl[8], "R5 code 0 reads stage 9");
      if (k <= 512 && decode_o) highs++;
      @(negedge clk) sel_i = 4'd1;
      #1 check(decode_o, mdl[9], "R5 code 1 reads stage 10");
    end
    vectors++;
    if (highs != 256) begin
      miscompares++;
      $display("FAIL R9 duty: high for %0d falls expected 256", highs);
    end
    check_all("R5 full chain all codes");

    // R8: test mode, three parallel sections
    pulse_clear();
    @(negedge clk) begin bypass_i = 1'b1; preset_i = 1'b1; clear_i = 1'b1; end
    for (int k = 1; k <= 260; k++) begin
      tick();
      step_model(2);
      check_all("R8 test mode sections");
    end
    @(negedge clk) begin preset_i = 1'b0; clear_i = 1'b0; end
    repeat (2) @(negedge clk);
    check_all("R8 count kept on test exit");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule